// File: doc/BRIEF.md
# Spectral Bin Window Splitter

This block sits after a frequency transform. It takes frames of frequency-domain samples on two channels at once. Each input beat carries the 16-bit in-phase and quadrature parts of one bin for channel 0 and channel 1. The block counts the bin index inside the frame and skips every bin below a programmable start bin. It then takes two back-to-back windows of equal width. The lower window goes to one output port and the upper window to the other. A swap bit reverses which port gets which window. Bins after the upper window are dropped. Every bin that reaches an output leaves as one 64-bit word that packs all four components.

A static 32-bit control word sets the configuration. It is assumed not to change while any of its enable bits is set. Both ports use valid/ready handshakes. The block holds no data storage. A bin routed to a port passes straight through in the same cycle, and the input stalls while that port is not ready. Bins that are dropped are always accepted at once.

Top module: `binSplitter`

## Requirements
- R1: Control bits 3..0 give the frame-size exponent m. A frame is M = 2^m accepted bins. Any value of m above 12 is treated as 12.
- R2: Control bits 15..4 give the start bin S. Bins with an index below S are accepted and produce no output word. S = 0 drops nothing.
- R3: The bin counter returns to 0 after the bin with index M-1 is accepted. This holds even when the windows reach past M, so later frames repeat the same routing.
- R4: With the swap bit (bit 26) at 0, bins S .. S+W-1 go to port F0 and bins S+W .. S+2W-1 go to port F1.
- R5: With the swap bit at 1, bins S .. S+W-1 go to port F1 and bins S+W .. S+2W-1 go to port F0.
- R6: Control bits 25..16 give the window width W, and a value of 0 means 1024. For a legal setting, each port emits exactly W words per frame.
- R7: Bins at index S+2W or higher are accepted and produce no output word.
- R8: Output is on when any of control bits 31..28 is 1. When all four are 0, neither port asserts valid, input is accepted and discarded, and the bin counter is held at 0. The first bin after enable is bin 0.
- R9: Each output word is {ch1 Q, ch1 I, ch0 Q, ch0 I}, with ch0 I in bits 15..0, ch0 Q in 31..16, ch1 I in 47..32 and ch1 Q in 63..48.
- R10: A bin routed to a port is accepted only in a cycle where that port's ready is high. While that port's ready is low, the input ready is low. A dropped bin is accepted regardless of either port's ready.
- R11: Control bit 27 has no effect on routing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Static configuration word |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inCh0I | input | 16 | Channel 0 in-phase |
| inCh0Q | input | 16 | Channel 0 quadrature |
| inCh1I | input | 16 | Channel 1 in-phase |
| inCh1Q | input | 16 | Channel 1 quadrature |
| f0Valid | output | 1 | Port F0 word valid |
| f0Ready | input | 1 | Port F0 sink ready |
| f0Data | output | 64 | Port F0 packed word |
| f1Valid | output | 1 | Port F1 word valid |
| f1Ready | input | 1 | Port F1 sink ready |
| f1Data | output | 64 | Port F1 packed word |

## Verification
The case that is hardest to reach from the ports is the counter wrap in a frame whose windows run past M. It only shows up in the second frame, when the routing repeats exactly or does not. The stimulus keeps such a setting enabled for two frames in a row, and also runs two full 4096-bin frames with an out-of-range exponent. Every word in every frame is checked against the bin index coded into its data. Backpressure is tested by dropping both readies on every third bin. This shows a stall on routed bins and none on dropped ones.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int CTRL_W    = 32;
  localparam int M_LSB     = 0;
  localparam int M_W       = 4;
  localparam int START_LSB = 4;
  localparam int START_W   = 12;
  localparam int WID_LSB   = 16;
  localparam int WID_W     = 10;
  localparam int SWAP_BIT  = 26;
  localparam int EN_LSB    = 28;
  localparam int EN_W      = 4;

  typedef struct packed {
    logic enable;
    logic toF0;
    logic toF1;
  } routeT;
endpackage

// File: rtl/binCtrl.sv
module binCtrl
  import splitPkg::*;
#(
  parameter int MAX_LOG = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              beatTaken,
  output routeT             route
);
  localparam int BIN_W = MAX_LOG;
  localparam int END_W = BIN_W + 2;
  localparam int SPW   = WID_W + 1;

  logic [M_W-1:0]     mRaw, mEff;
  logic [START_W-1:0] startBin;
  logic [WID_W-1:0]   widRaw;
  logic [SPW-1:0]     widEff;
  logic               swapOn, enabled;
  logic [BIN_W:0]     frameLen;
  logic [BIN_W-1:0]   frameMax, binCnt;
  logic [END_W-1:0]   binWide, lowBeg, lowEnd, highEnd;
  logic               inLow, inHigh, lastBin;

  always_comb begin
    mRaw     = ctrlWord[M_LSB +: M_W];
    startBin = ctrlWord[START_LSB +: START_W];
    widRaw   = ctrlWord[WID_LSB +: WID_W];
    swapOn   = ctrlWord[SWAP_BIT];
    enabled  = |ctrlWord[EN_LSB +: EN_W];
    mEff     = (mRaw > M_W'(MAX_LOG)) ? M_W'(MAX_LOG) : mRaw;
    frameLen = (BIN_W+1)'(1) << mEff;
    frameMax = BIN_W'(frameLen - 1'b1);
    widEff   = (widRaw == '0) ? SPW'(1 << WID_W) : SPW'(widRaw);
    binWide  = END_W'(binCnt);
    lowBeg   = END_W'(startBin);
    lowEnd   = lowBeg + END_W'(widEff);
    highEnd  = lowEnd + END_W'(widEff);
    inLow    = (binWide >= lowBeg) && (binWide < lowEnd);
    inHigh   = (binWide >= lowEnd) && (binWide < highEnd);
    lastBin  = (binCnt == frameMax);
    route.enable = enabled;
    route.toF0   = enabled && (swapOn ? inHigh : inLow);
    route.toF1   = enabled && (swapOn ? inLow : inHigh);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enabled)   binCnt <= '0;
    else if (beatTaken)      binCnt <= lastBin ? '0 : binCnt + 1'b1;
  end

  AST_BIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    binCnt <= frameMax); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && beatTaken && lastBin) |=> (binCnt == '0)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && !beatTaken) |=> $stable(binCnt)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> (binCnt == '0)); // R8
endmodule

// File: rtl/binPath.sv
module binPath
  import splitPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  routeT             route,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inCh0I,
  input  logic [DATA_W-1:0] inCh0Q,
  input  logic [DATA_W-1:0] inCh1I,
  input  logic [DATA_W-1:0] inCh1Q,
  output logic              beatTaken,
  output logic [1:0]        portValid,
  input  logic [1:0]        portReady,
  output logic [4*DATA_W-1:0] portData [2]
);
  localparam int WORD_W = 4 * DATA_W;

  logic [WORD_W-1:0] packed4;
  logic [1:0]        portSel;

  assign packed4 = {inCh1Q, inCh1I, inCh0Q, inCh0I};
  assign portSel = {route.toF1, route.toF0};

  for (genvar p = 0; p < 2; p++) begin : gPort
    assign portValid[p] = inValid && portSel[p];
    assign portData[p]  = packed4;
  end

  always_comb begin
    inReady = 1'b1;
    for (int p = 0; p < 2; p++)
      if (portSel[p]) inReady = portReady[p];
  end
  assign beatTaken = inValid && inReady;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !(portValid[0] && portValid[1])); // R4
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !route.enable |-> (portValid == 2'b00)); // R8
  AST_STALL_F0: assert property (@(posedge clk) disable iff (!rstN)
    (portValid[0] && !portReady[0]) |-> !inReady); // R10
  AST_STALL_F1: assert property (@(posedge clk) disable iff (!rstN)
    (portValid[1] && !portReady[1]) |-> !inReady); // R10
endmodule

// File: rtl/binSplitter.sv
module binSplitter
  import splitPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LOG = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         ctrlWord,
  input  logic                inValid,
  output logic                inReady,
  input  logic [DATA_W-1:0]   inCh0I,
  input  logic [DATA_W-1:0]   inCh0Q,
  input  logic [DATA_W-1:0]   inCh1I,
  input  logic [DATA_W-1:0]   inCh1Q,
  output logic                f0Valid,
  input  logic                f0Ready,
  output logic [4*DATA_W-1:0] f0Data,
  output logic                f1Valid,
  input  logic                f1Ready,
  output logic [4*DATA_W-1:0] f1Data
);
  routeT             route;
  logic              beatTaken;
  logic [1:0]        portValid;
  logic [4*DATA_W-1:0] portData [2];

  binCtrl #(.MAX_LOG(MAX_LOG)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .beatTaken(beatTaken), .route(route)
  );

  binPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .route(route),
    .inValid(inValid), .inReady(inReady),
    .inCh0I(inCh0I), .inCh0Q(inCh0Q), .inCh1I(inCh1I), .inCh1Q(inCh1Q),
    .beatTaken(beatTaken), .portValid(portValid),
    .portReady({f1Ready, f0Ready}), .portData(portData)
  );

  assign f0Valid = portValid[0];
  assign f1Valid = portValid[1];
  assign f0Data  = portData[0];
  assign f1Data  = portData[1];
endmodule

// File: tb/binSplitter_test.sv
module binSplitter_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] ctrlWord;
  logic        inValid, inReady;
  logic [15:0] inCh0I, inCh0Q, inCh1I, inCh1Q;
  logic        f0Valid, f0Ready, f1Valid, f1Ready;
  logic [63:0] f0Data, f1Data;

  int checks = 0;
  int errors = 0;
  int f0Seen, f1Seen, beatErr;
  bit done = 0;

  always #5 clk = ~clk;

  binSplitter uut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .inValid(inValid), .inReady(inReady),
    .inCh0I(inCh0I), .inCh0Q(inCh0Q), .inCh1I(inCh1I), .inCh1Q(inCh1Q),
    .f0Valid(f0Valid), .f0Ready(f0Ready), .f0Data(f0Data),
    .f1Valid(f1Valid), .f1Ready(f1Ready), .f1Data(f1Data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] wordOf(input int b);
    logic [15:0] v;
    v = 16'(b);
    return {~v, v + 16'h2000, v ^ 16'hA5A5, v};
  endfunction

  function automatic int routeOf(input int b, input int st, input int wd, input bit sw);
    int w;
    w = (wd == 0) ? 1024 : wd;
    if (b >= st && b < st + w)         return sw ? 2 : 1;
    if (b >= st + w && b < st + 2 * w) return sw ? 1 : 2;
    return 0;
  endfunction

  function automatic logic [31:0] mkCtrl(input int m, input int st, input int wd,
                                         input bit sw, input bit rsv, input int en);
    return {4'(en), rsv, sw, 10'(wd), 12'(st), 4'(m)};
  endfunction

  // one bin; routeExp: 0 drop, 1 F0, 2 F1
  task automatic pushBin(input int b, input int routeExp, input bit stall);
    bit took;
    @(negedge clk);
    inValid = 1'b1;
    inCh0I = 16'(b); inCh0Q = 16'(b) ^ 16'hA5A5;
    inCh1I = 16'(b) + 16'h2000; inCh1Q = ~16'(b);
    f0Ready = !stall; f1Ready = !stall;
    took = 0;
    while (!took) begin
      #1;
      if (stall && !f0Ready) begin
        // R10: routed bins wait, dropped bins pass
        if ((routeExp != 0) == inReady) beatErr++;
      end
      if (inValid && inReady) begin
        took = 1;
        if ((f0Valid && f0Ready) != (routeExp == 1)) beatErr++;
        if ((f1Valid && f1Ready) != (routeExp == 2)) beatErr++;
        if (f0Valid && f0Ready) begin
          f0Seen++;
          if (f0Data != wordOf(b)) beatErr++;
        end
        if (f1Valid && f1Ready) begin
          f1Seen++;
          if (f1Data != wordOf(b)) beatErr++;
        end
      end
      @(negedge clk);
      f0Ready = 1'b1; f1Ready = 1'b1;
    end
    inValid = 1'b0;
  endtask

  task automatic runFrames(input int m, input int st, input int wd, input bit sw,
                           input bit rsv, input int nFrames, input bit stall,
                           input string req);
    int mE, mLen, e0, e1;
    @(negedge clk);
    ctrlWord = 32'h0;
    @(negedge clk);
    ctrlWord = mkCtrl(m, st, wd, sw, rsv, 4'b0100);
    mE = (m > 12) ? 12 : m;
    mLen = 1 << mE;
    e0 = 0; e1 = 0;
    for (int b = 0; b < mLen; b++) begin
      if (routeOf(b, st, wd, sw) == 1) e0++;
      if (routeOf(b, st, wd, sw) == 2) e1++;
    end
    for (int f = 0; f < nFrames; f++) begin
      f0Seen = 0; f1Seen = 0; beatErr = 0;
      for (int b = 0; b < mLen; b++)
        pushBin(b, routeOf(b, st, wd, sw), stall && (b % 3 == 0));
      check(f0Seen == e0, req, "F0 words per frame", f0Seen, e0);
      check(f1Seen == e1, req, "F1 words per frame", f1Seen, e1);
      check(beatErr == 0, req, "beat routing/data/handshake errors", beatErr, 0);
    end
  endtask

  task automatic testReset();
    ctrlWord = 32'h0; inValid = 1'b0; f0Ready = 1'b1; f1Ready = 1'b1;
    inCh0I = '0; inCh0Q = '0; inCh1I = '0; inCh1Q = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!f0Valid && !f1Valid, "R8", "valids after reset", {f1Valid, f0Valid}, 0);
    check(inReady, "R8", "inReady after reset", inReady, 1);
  endtask

  task automatic testBasic();      // R2 R4 R7 R9: S=2 W=3 M=16
    runFrames(4, 2, 3, 1'b0, 1'b0, 1, 1'b0, "R4");
  endtask

  task automatic testSwap();       // R5 R11: reserved bit set, S=0
    runFrames(4, 0, 4, 1'b1, 1'b1, 1, 1'b0, "R5");
  endtask

  task automatic testWidthZero();  // R6: width 0 means 1024 per port
    runFrames(12, 5, 0, 1'b0, 1'b0, 1, 1'b0, "R6");
  endtask

  task automatic testClampM();     // R1: m=13 treated as 12
    runFrames(13, 4094, 1, 1'b0, 1'b0, 2, 1'b0, "R1");
  endtask

  task automatic testStall();      // R10
    runFrames(3, 1, 2, 1'b0, 1'b0, 2, 1'b1, "R10");
  endtask

  task automatic testOverrun();    // R3: window beyond M, frames repeat
    runFrames(3, 6, 2, 1'b0, 1'b0, 2, 1'b0, "R3");
  endtask

  task automatic testDisabled();   // R8
    int seen;
    seen = 0;
    @(negedge clk);
    ctrlWord = mkCtrl(3, 0, 1, 1'b0, 1'b0, 0);
    for (int b = 0; b < 5; b++) begin
      @(negedge clk);
      inValid = 1'b1; inCh0I = 16'(b);
      #1;
      if (f0Valid || f1Valid || !inReady) seen++;
    end
    @(negedge clk);
    inValid = 1'b0;
    check(seen == 0, "R8", "output or stall while disabled", seen, 0);
    // enable without passing through runFrames' own disable: first bin is bin 0
    ctrlWord = mkCtrl(3, 0, 1, 1'b0, 1'b0, 4'b0001);
    f0Seen = 0; f1Seen = 0; beatErr = 0;
    for (int b = 0; b < 8; b++) pushBin(b, routeOf(b, 0, 1, 1'b0), 1'b0);
    check(beatErr == 0 && f0Seen == 1 && f1Seen == 1, "R8",
          "first frame after enable starts at bin 0", beatErr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testBasic();
    testSwap();
    testWidthZero();
    testClampM();
    testStall();
    testOverrun();
    testDisabled();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule